// File: doc/BRIEF.md
# Ones-Complement Adder with Operand Injection

This block is the arithmetic core of a 16-bit ones-complement processor datapath. It holds two operand registers, X and Y, and a carry-in flop, and forms their sum combinationally. By default the carry out of the top bit wraps around into the bottom bit, so the result is a proper ones-complement sum. A latched inhibit can switch that wrap-around off. The word carries two sign bits: bit 16 is the true sign and bit 15 is the overflow-detecting copy.

A sequencer outside the block drives active-low control pulses, each one clock cycle long. Some pulses load Y from the shared write bus, either straight, truncated to 12 bits, or shifted left by one place. Others force constants into X, copy the accumulator into X over a private path, clear X on a branch condition, or set the carry-in. Two read pulses return the sum to the write bus, either as the whole word or with bit 15 duplicated into bit 16. Register updates take effect at the clock edge on which the pulse is sampled. The readout is combinational from the current register contents.

Top module: `oc_adder_unit`

## Requirements
- R1: After reset X, Y, carry-in and the wrap-around inhibit are all zero, and `busDrive` is low with `busOut` equal to zero.
- R2: The sum U is X + Y + carry-in modulo 2^16. While the inhibit is clear, the carry out of bit 16 is added back into bit 1 in the same cycle.
- R3: When `readSumExtN` is low and `readSumN` is high, `busOut[13:0]` = U[13:0] and both `busOut[15]` and `busOut[14]` equal U[14]. `busDrive` is high.
- R4: `loadYN` loads the whole bus into Y. `loadY12N` loads bus bits [11:0] into Y and zeroes Y[15:12]. Either pulse clears X, and clears carry-in unless `carryInN` is low in the same cycle.
- R5: `loadYShiftN` clears X and loads Y[14:1] = bus[13:0] and Y[15] = bus[15]. Bus bit 14 is dropped. Y[0] = bus[15] when no suppression condition holds.
- R6: During `loadYShiftN`, Y[0] is forced to zero in any of three cases: the wrap-around inhibit is set, `shiftIncActive` is high, or `fillGuardN` is low while `lBit15` is high.
- R7: The X constant pulses work as follows. `setX15N` ORs 0x4000 into X. `minusOneXN` sets X to 0xFFFE. `plusOneXN` sets X to 0x0001. `plusTwoXN` sets X to 0x0002.
- R8: `copyAN` ORs `regA` into X. When a clearing pulse and a setting pulse hit X in the same cycle, X is cleared first and then the set bits are applied.
- R9: `clrXCondN` clears X only when `brBit1` is 0. When `brBit1` is 1, X is left unchanged.
- R10: `carryInN` sets carry-in, which raises the sum by one. A Y load clears carry-in unless `carryInN` is also low.
- R11: `eacHoldN` sets the wrap-around inhibit and `eacFreeN` clears it. If both are low in the same cycle, the inhibit is set.
- R12: With no pulse low, X, Y and carry-in hold their values. With neither read pulse low, `busDrive` is 0 and `busOut` is 0. If both read pulses are low, the full readout wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busIn | input | 16 | Write bus value offered for Y loads |
| regA | input | 16 | Accumulator contents on the private path into X |
| brBit1 | input | 1 | Branch bit qualifying the conditional X clear |
| lBit15 | input | 1 | Bit 15 of the lower-product register |
| shiftIncActive | input | 1 | High while a shift-increment sequence runs |
| copyAN | input | 1 | Active low: OR accumulator into X |
| setX15N | input | 1 | Active low: set X bit 15 |
| minusOneXN | input | 1 | Active low: X becomes 0xFFFE |
| plusOneXN | input | 1 | Active low: X becomes 0x0001 |
| plusTwoXN | input | 1 | Active low: X becomes 0x0002 |
| carryInN | input | 1 | Active low: set carry-in |
| clrXCondN | input | 1 | Active low: clear X if brBit1 is 0 |
| loadYN | input | 1 | Active low: full Y load |
| loadY12N | input | 1 | Active low: 12-bit Y load |
| loadYShiftN | input | 1 | Active low: shifted Y load |
| fillGuardN | input | 1 | Active low: block shifted fill when lBit15 is 1 |
| eacHoldN | input | 1 | Active low: set wrap-around inhibit |
| eacFreeN | input | 1 | Active low: clear wrap-around inhibit |
| readSumN | input | 1 | Active low: drive full sum |
| readSumExtN | input | 1 | Active low: drive sign-extended sum |
| busOut | output | 16 | Sum readout, zero when not driving |
| busDrive | output | 1 | High while a readout is driven |

## Verification
A wrong operand register or carry flop shows up at `busOut` on the very next read pulse, one cycle after the offending load. A stale wrap-around inhibit is harder to see. It shows only when the operands produce a carry out of bit 16, or when a shifted Y load has bus bit 16 set. For that reason the sequences pair each inhibit change with operands such as two negative numbers, which expose it. A wrong suppression of the shifted fill changes only bit 0 of the result, so each suppression case is read back with the sign bit set on the bus.

// File: rtl/oc_adder_pkg.sv
package oc_adder_pkg;
  localparam int WORD_W = 16;
  localparam int LOW_W  = 12;
  localparam int SIGN_B = WORD_W - 1;
  localparam int OVF_B  = WORD_W - 2;

  typedef enum logic [1:0] {Y_HOLD, Y_FULL, Y_LOW, Y_SHIFT} yMode_e;
  typedef enum logic [1:0] {RD_NONE, RD_FULL, RD_EXT} rdMode_e;

  typedef struct packed {
    logic              xClear;
    logic              xCopyA;
    logic [WORD_W-1:0] xConst;
    yMode_e            yMode;
    logic              ciSet;
    logic              ciClear;
    logic              eacOn;
    logic              eacOff;
    logic              fillBlock;
    rdMode_e           rdMode;
  } strobe_t;
endpackage

// File: rtl/oc_adder_ctrl.sv
module oc_adder_ctrl
  import oc_adder_pkg::*;
(
  input  logic    brBit1,
  input  logic    lBit15,
  input  logic    shiftIncActive,
  input  logic    copyAN,
  input  logic    setX15N,
  input  logic    minusOneXN,
  input  logic    plusOneXN,
  input  logic    plusTwoXN,
  input  logic    carryInN,
  input  logic    clrXCondN,
  input  logic    loadYN,
  input  logic    loadY12N,
  input  logic    loadYShiftN,
  input  logic    fillGuardN,
  input  logic    eacHoldN,
  input  logic    eacFreeN,
  input  logic    readSumN,
  input  logic    readSumExtN,
  output strobe_t stb
);
  localparam logic [WORD_W-1:0] K_BIT15 = WORD_W'(1) << OVF_B;
  localparam logic [WORD_W-1:0] K_MONE  = ~(WORD_W'(1));
  localparam logic [WORD_W-1:0] K_PONE  = WORD_W'(1);
  localparam logic [WORD_W-1:0] K_PTWO  = WORD_W'(2);

  logic yAny;

  always_comb begin
    yAny = !loadYN || !loadY12N || !loadYShiftN;
    stb = '0;
    stb.xCopyA = !copyAN;
    stb.xConst = (!setX15N    ? K_BIT15 : '0)
               | (!minusOneXN ? K_MONE  : '0)
               | (!plusOneXN  ? K_PONE  : '0)
               | (!plusTwoXN  ? K_PTWO  : '0);
    stb.xClear = yAny || !minusOneXN || !plusOneXN || !plusTwoXN
               || (!clrXCondN && !brBit1);
    if (!loadYN)           stb.yMode = Y_FULL;
    else if (!loadYShiftN) stb.yMode = Y_SHIFT;
    else if (!loadY12N)    stb.yMode = Y_LOW;
    else                   stb.yMode = Y_HOLD;
    stb.ciSet     = !carryInN;
    stb.ciClear   = yAny;
    stb.eacOn     = !eacHoldN;
    stb.eacOff    = !eacFreeN;
    stb.fillBlock = shiftIncActive || (!fillGuardN && lBit15);
    if (!readSumN)         stb.rdMode = RD_FULL;
    else if (!readSumExtN) stb.rdMode = RD_EXT;
    else                   stb.rdMode = RD_NONE;
  end
endmodule

// File: rtl/oc_adder_dp.sv
module oc_adder_dp
  import oc_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] busIn,
  input  logic [WORD_W-1:0] regA,
  output logic [WORD_W-1:0] busOut,
  output logic              busDrive
);
  logic [WORD_W-1:0] xReg, yReg, xNext, yNext, sumVal;
  logic [WORD_W:0]   rawSum;
  logic              ciReg, eacInhibit, shiftFill;

  always_comb begin
    xNext = (stb.xClear ? '0 : xReg) | stb.xConst | (stb.xCopyA ? regA : '0);
    shiftFill = busIn[SIGN_B] && !eacInhibit && !stb.fillBlock;
    unique case (stb.yMode)
      Y_FULL:  yNext = busIn;
      Y_LOW:   yNext = {{(WORD_W-LOW_W){1'b0}}, busIn[LOW_W-1:0]};
      Y_SHIFT: yNext = {busIn[SIGN_B], busIn[OVF_B-1:0], shiftFill};
      default: yNext = yReg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xReg       <= '0;
      yReg       <= '0;
      ciReg      <= 1'b0;
      eacInhibit <= 1'b0;
    end else begin
      xReg <= xNext;
      yReg <= yNext;
      if (stb.ciSet)        ciReg <= 1'b1;
      else if (stb.ciClear) ciReg <= 1'b0;
      if (stb.eacOn)        eacInhibit <= 1'b1;
      else if (stb.eacOff)  eacInhibit <= 1'b0;
    end
  end

  always_comb begin
    rawSum = {1'b0, xReg} + {1'b0, yReg} + {{WORD_W{1'b0}}, ciReg};
    sumVal = rawSum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, rawSum[WORD_W] & !eacInhibit};
    busDrive = (stb.rdMode != RD_NONE);
    unique case (stb.rdMode)
      RD_FULL: busOut = sumVal;
      RD_EXT:  busOut = {sumVal[OVF_B], sumVal[OVF_B], sumVal[OVF_B-1:0]};
      default: busOut = '0;
    endcase
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.xClear && !stb.xCopyA && stb.xConst == '0 && stb.yMode == Y_HOLD
     && !stb.ciSet && !stb.ciClear)
    |=> ($stable(xReg) && $stable(yReg) && $stable(ciReg)));

  p_full_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.yMode == Y_FULL) |=> (yReg == $past(busIn) && xReg == $past(stb.xConst | (stb.xCopyA ? regA : '0))));

  p_shift_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.yMode == Y_SHIFT) |=> (yReg[SIGN_B] == $past(busIn[SIGN_B])
                                && yReg[OVF_B:1] == $past(busIn[OVF_B-1:0])));

  p_fill_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.yMode == Y_SHIFT && (eacInhibit || stb.fillBlock)) |=> !yReg[0]);

  p_ci_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ciClear && !stb.ciSet) |=> !ciReg);

  p_inhibit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb.eacOn |=> eacInhibit);

  p_ext_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdMode == RD_EXT) |-> (busOut[SIGN_B] == busOut[OVF_B] && busDrive));

  p_idle_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdMode == RD_NONE) |-> (busOut == '0 && !busDrive));
endmodule

// File: rtl/oc_adder_unit.sv
module oc_adder_unit
  import oc_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] busIn,
  input  logic [WORD_W-1:0] regA,
  input  logic              brBit1,
  input  logic              lBit15,
  input  logic              shiftIncActive,
  input  logic              copyAN,
  input  logic              setX15N,
  input  logic              minusOneXN,
  input  logic              plusOneXN,
  input  logic              plusTwoXN,
  input  logic              carryInN,
  input  logic              clrXCondN,
  input  logic              loadYN,
  input  logic              loadY12N,
  input  logic              loadYShiftN,
  input  logic              fillGuardN,
  input  logic              eacHoldN,
  input  logic              eacFreeN,
  input  logic              readSumN,
  input  logic              readSumExtN,
  output logic [WORD_W-1:0] busOut,
  output logic              busDrive
);
  strobe_t stb;

  oc_adder_ctrl u_ctrl (
    .brBit1(brBit1), .lBit15(lBit15), .shiftIncActive(shiftIncActive),
    .copyAN(copyAN), .setX15N(setX15N), .minusOneXN(minusOneXN),
    .plusOneXN(plusOneXN), .plusTwoXN(plusTwoXN), .carryInN(carryInN),
    .clrXCondN(clrXCondN), .loadYN(loadYN), .loadY12N(loadY12N),
    .loadYShiftN(loadYShiftN), .fillGuardN(fillGuardN), .eacHoldN(eacHoldN),
    .eacFreeN(eacFreeN), .readSumN(readSumN), .readSumExtN(readSumExtN),
    .stb(stb)
  );

  oc_adder_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busIn(busIn), .regA(regA),
    .busOut(busOut), .busDrive(busDrive)
  );
endmodule

// File: tb/oc_adder_unit_tb.sv
module oc_adder_unit_tb;
  localparam int P_A2X = 0, P_B15 = 1, P_MONE = 2, P_PONE = 3, P_PTWO = 4,
                 P_CI = 5, P_CLXC = 6, P_WY = 7, P_WY12 = 8, P_WYD = 9,
                 P_GUARD = 10, P_HOLD = 11, P_FREE = 12, P_RU = 13, P_RUS = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] busIn = '0, regA = '0;
  logic brBit1 = 1'b0, lBit15 = 1'b0, shiftIncActive = 1'b0;
  logic [14:0] pul = '0;
  logic [15:0] busOut;
  logic busDrive;
  int checks = 0, errors = 0;
  logic [15:0] expQ[$];
  string tagQ[$];
  bit done = 0;

  always #10 clk = ~clk;

  oc_adder_unit u_dut (
    .clk(clk), .rst_n(rst_n), .busIn(busIn), .regA(regA), .brBit1(brBit1),
    .lBit15(lBit15), .shiftIncActive(shiftIncActive),
    .copyAN(~pul[P_A2X]), .setX15N(~pul[P_B15]), .minusOneXN(~pul[P_MONE]),
    .plusOneXN(~pul[P_PONE]), .plusTwoXN(~pul[P_PTWO]), .carryInN(~pul[P_CI]),
    .clrXCondN(~pul[P_CLXC]), .loadYN(~pul[P_WY]), .loadY12N(~pul[P_WY12]),
    .loadYShiftN(~pul[P_WYD]), .fillGuardN(~pul[P_GUARD]),
    .eacHoldN(~pul[P_HOLD]), .eacFreeN(~pul[P_FREE]),
    .readSumN(~pul[P_RU]), .readSumExtN(~pul[P_RUS]),
    .busOut(busOut), .busDrive(busDrive)
  );

  function automatic logic [14:0] bit1(input int i);
    return 15'(1) << i;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [14:0] p, input logic [15:0] bus);
    pul = p;
    busIn = bus;
    @(posedge clk); #1;
    pul = '0;
  endtask

  task automatic readSum(input bit ext, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    pul = ext ? bit1(P_RUS) : bit1(P_RU);
    @(posedge clk); #1;
    pul = '0;
  endtask

  // monitor: pops one expectation per driven readout
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busDrive) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected drive", busOut, 16'h0);
        end else begin
          automatic logic [15:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(busOut == e, t, busOut, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 16'h0, 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(busDrive == 1'b0 && busOut == 16'h0, "R1 idle bus after reset", busOut, 16'h0);
    @(posedge clk); #1;
    readSum(0, 16'h0000, "R1 reset sum");

    apply(bit1(P_WY), 16'h1234);
    apply(bit1(P_PONE), 16'h0);
    readSum(0, 16'h1235, "R2 plain sum with plusOne R7");

    apply(bit1(P_WY), 16'hFFFE);
    apply(bit1(P_MONE), 16'h0);
    readSum(0, 16'hFFFD, "R2 end-around carry");
    readSum(1, 16'hFFFD, "R3 ext readout negative");

    apply(bit1(P_HOLD), 16'h0);
    readSum(0, 16'hFFFC, "R11 inhibit drops carry");
    apply(bit1(P_WYD), 16'h8001);
    readSum(0, 16'h8002, "R6 fill blocked by inhibit");
    apply(bit1(P_HOLD) | bit1(P_FREE), 16'h0);
    apply(bit1(P_WYD), 16'h8001);
    readSum(0, 16'h8002, "R11 set wins over clear");
    apply(bit1(P_FREE), 16'h0);
    apply(bit1(P_WYD), 16'h8001);
    readSum(0, 16'h8003, "R5 shifted load with fill");
    apply(bit1(P_MONE), 16'h0);
    readSum(0, 16'h8002, "R11 carry restored after clear");

    apply(bit1(P_WY12), 16'hFFFF);
    readSum(1, 16'h0FFF, "R4 12-bit load ext readout");
    apply(bit1(P_B15), 16'h0);
    readSum(1, 16'hCFFF, "R3 bit 15 copied to bit 16");
    readSum(0, 16'h4FFF, "R7 set bit 15");
    apply(bit1(P_PTWO), 16'h0);
    readSum(0, 16'h1001, "R7 plusTwo replaces X");
    apply(bit1(P_MONE), 16'h0);
    readSum(0, 16'h0FFE, "R7 minusOne constant");

    apply(bit1(P_CI), 16'h0);
    readSum(0, 16'h0FFF, "R10 carry-in adds one");
    apply(bit1(P_WY) | bit1(P_CI), 16'h0005);
    readSum(0, 16'h0006, "R10 carry-in survives same-cycle load");
    apply(bit1(P_WY), 16'h0005);
    readSum(0, 16'h0005, "R10 load clears carry-in R4");

    regA = 16'h0100;
    apply(bit1(P_A2X) | bit1(P_PTWO), 16'h0);
    readSum(0, 16'h0107, "R8 clear then set");
    regA = 16'h0010;
    apply(bit1(P_A2X), 16'h0);
    readSum(0, 16'h0117, "R8 copy ORs into X");

    brBit1 = 1'b1;
    apply(bit1(P_CLXC), 16'h0);
    readSum(0, 16'h0117, "R9 no clear when branch bit set");
    brBit1 = 1'b0;
    apply(bit1(P_CLXC), 16'h0);
    readSum(0, 16'h0005, "R9 clear when branch bit zero");

    shiftIncActive = 1'b1;
    apply(bit1(P_WYD), 16'h8000);
    readSum(0, 16'h8000, "R6 fill blocked by shift-increment");
    shiftIncActive = 1'b0;
    lBit15 = 1'b1;
    apply(bit1(P_WYD) | bit1(P_GUARD), 16'h8000);
    readSum(0, 16'h8000, "R6 fill blocked by guard");
    lBit15 = 1'b0;
    apply(bit1(P_WYD) | bit1(P_GUARD), 16'h8000);
    readSum(0, 16'h8001, "R5 guard without L15 keeps fill");
    lBit15 = 1'b1;
    apply(bit1(P_WYD), 16'h8000);
    readSum(0, 16'h8001, "R5 L15 without guard keeps fill");
    apply(bit1(P_WYD), 16'h4000);
    readSum(0, 16'h0000, "R5 bus bit 14 dropped");

    apply(bit1(P_WY), 16'h4000);
    pul = '0;
    busIn = 16'hAAAA;
    @(negedge clk);
    check(busDrive == 1'b0 && busOut == 16'h0, "R12 no drive when idle", busOut, 16'h0);
    @(posedge clk); #1;
    readSum(0, 16'h4000, "R12 hold over idle cycle");
    expQ.push_back(16'h4000);
    tagQ.push_back("R12 full readout wins");
    pul = bit1(P_RU) | bit1(P_RUS);
    @(posedge clk); #1;
    pul = '0;

    repeat (2) @(posedge clk);
    check(expQ.size() == 0, "R12 all readouts seen", 16'(expQ.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule